// File: doc/BRIEF.md
# Character LCD Four-Bit Write Controller

This block sends bytes to a character display controller over a four-bit parallel bus and only ever writes. A host hands over one byte at a time on a valid/ready handshake, with a flag that marks the byte as character data or as an instruction. The block sends the byte as two nibbles on the upper data lines, high nibble first. Each nibble is latched by an enable strobe, and the register-select line is set up before the strobe rises and held after it falls.

After the second strobe the block stays busy for a settle time chosen from the byte itself. Clear-display and return-home instructions get the long time and every other byte gets the short one. It never reads a busy flag. Every width and delay is given in nanoseconds and turned into clock cycles from the clock frequency in MHz, always rounding up. Power-on initialization, contrast, backlight and any character logic are left to the host.

Top module: `lcd_nibble_writer`

## Requirements
- R1: Each accepted byte produces exactly two enable strobes. The nibble latched on the first falling edge is byte[7:4] and the nibble on the second is byte[3:0], both on `lcd_d[3:0]`.
- R2: `lcd_rs` equals the byte's `host_is_data` flag (0 = instruction, 1 = character data) during both strobes.
- R3: `lcd_rw` is 0 at all times.
- R4: Enable stays high for exactly EN_CYC = ceil(EN_NS*CLK_MHZ/1000) cycles per strobe. Every cycle count in this list uses the same round-up rule, with a minimum of one cycle.
- R5: `lcd_d` and `lcd_rs` are unchanged for at least EN_CYC cycles before enable rises, stay unchanged while enable is high, and stay unchanged for at least HOLD_CYC cycles after enable falls.
- R6: From the fall of the first strobe to the rise of the second strobe there are at least GAP_CYC cycles.
- R7: An instruction byte (`host_is_data`=0) with byte[7:2]=0 and byte[1:0]≠0 (values 0x01, 0x02, 0x03) makes ready return exactly HOLD_CYC+LONG_CYC cycles after the second enable fall.
- R8: Every other byte, including data bytes 0x01–0x03, makes ready return exactly HOLD_CYC+SHORT_CYC cycles after the second enable fall.
- R9: `host_ready` is high only while idle, and is low from the cycle after a handshake until the settle time ends. The byte and flag are captured at the handshake. Inputs and `host_valid` seen while busy have no effect.
- R10: While `rst` is high, and in the first cycle after it falls, `lcd_en`=0, `lcd_d`=0 and `host_ready`=1. This holds even when reset lands in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host offers a byte |
| host_ready | output | 1 | Block idle and able to take a byte |
| host_byte | input | 8 | Byte to send |
| host_is_data | input | 1 | 1 = character data, 0 = instruction |
| lcd_d | output | 4 | Nibble lines to the display's upper data pins |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write line, held low |
| lcd_en | output | 1 | Enable strobe |

## Verification
The end of one byte's settle time and the handshake of the next byte can fall in the same cycle. Ready rises, and a valid that is already held high is taken in that same cycle. The bench provokes this by keeping `host_valid` high with a second byte through the whole first transfer. It then expects ready to be high for exactly one cycle, the second byte's nibbles to be latched, and the first byte's settle time to be intact. The same run also checks that the inputs the bench changes while busy leave the first byte's nibbles untouched.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    typedef enum logic [3:0] {
        W_IDLE    = 4'd0,
        W_SETUP_H = 4'd1,
        W_PULSE_H = 4'd2,
        W_HOLD_H  = 4'd3,
        W_SETUP_L = 4'd4,
        W_PULSE_L = 4'd5,
        W_HOLD_L  = 4'd6,
        W_SETTLE  = 4'd7
    } wstate_e;

    typedef struct packed {
        wstate_e    st;
        logic [3:0] lo;
        logic       long_w;
        logic       en;
        logic       rs;
        logic [3:0] d;
    } ctl_t;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
        longint unsigned p;
        p = (64'(ns) * 64'(mhz) + 64'd999) / 64'd1000;
        if (p == 64'd0) p = 64'd1;
        return 32'(p);
    endfunction

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcdw_cmd_class.sv
module lcdw_cmd_class (
    input  logic [7:0] byt,
    input  logic       is_data,
    output logic       long_w
);
    // Clear-display (0x01) and return-home (0x02/0x03) need the long settle.
    always_comb begin
        long_w = !is_data && (byt[7:2] == 6'b0) && (byt[1:0] != 2'b00);
    end
endmodule

// File: rtl/lcdw_timer.sv
module lcdw_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcdw_dwell.sv
module lcdw_dwell
    import lcdw_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter int unsigned SETUP1_C = 1,
    parameter int unsigned PULSE_C  = 1,
    parameter int unsigned HOLD_C   = 1,
    parameter int unsigned SETUP2_C = 1,
    parameter int unsigned SHORT_C  = 1,
    parameter int unsigned LONG_C   = 1
) (
    input  wstate_e      st,
    input  logic         long_w,
    output logic [W-1:0] val
);
    // Value loaded into the timer on entry to a state: dwell cycles minus one.
    always_comb begin
        unique case (st)
            W_SETUP_H: val = W'(SETUP1_C - 1);
            W_PULSE_H,
            W_PULSE_L: val = W'(PULSE_C - 1);
            W_HOLD_H,
            W_HOLD_L:  val = W'(HOLD_C - 1);
            W_SETUP_L: val = W'(SETUP2_C - 1);
            W_SETTLE:  val = long_w ? W'(LONG_C - 1) : W'(SHORT_C - 1);
            default:   val = '0;
        endcase
    end
endmodule

// File: rtl/lcd_nibble_writer.sv
module lcd_nibble_writer
    import lcdw_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 200,
    parameter int unsigned EN_NS    = 450,
    parameter int unsigned HOLD_NS  = 20,
    parameter int unsigned GAP_NS   = 1000,
    parameter int unsigned SHORT_NS = 37000,
    parameter int unsigned LONG_NS  = 1640000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_valid,
    output logic       host_ready,
    input  logic [7:0] host_byte,
    input  logic       host_is_data,
    output logic [3:0] lcd_d,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_en
);
    localparam int unsigned EN_CYC    = ns2cyc(EN_NS, CLK_MHZ);
    localparam int unsigned HOLD_CYC  = ns2cyc(HOLD_NS, CLK_MHZ);
    localparam int unsigned GAP_CYC   = ns2cyc(GAP_NS, CLK_MHZ);
    localparam int unsigned SHORT_CYC = ns2cyc(SHORT_NS, CLK_MHZ);
    localparam int unsigned LONG_CYC  = ns2cyc(LONG_NS, CLK_MHZ);
    localparam int unsigned SETUP2    = (GAP_CYC > HOLD_CYC) ?
                                        imax(EN_CYC, GAP_CYC - HOLD_CYC) : EN_CYC;
    localparam int unsigned MAX_CYC   = imax(imax(imax(EN_CYC, HOLD_CYC), SETUP2),
                                             imax(SHORT_CYC, LONG_CYC));
    localparam int unsigned CW        = $clog2(MAX_CYC + 1);

    ctl_t          r_q, r_d;
    logic          t_load, t_exp, cls_long;
    logic [CW-1:0] t_val;

    lcdw_cmd_class cls_i (
        .byt     (host_byte),
        .is_data (host_is_data),
        .long_w  (cls_long)
    );

    lcdw_dwell #(
        .W(CW), .SETUP1_C(EN_CYC), .PULSE_C(EN_CYC), .HOLD_C(HOLD_CYC),
        .SETUP2_C(SETUP2), .SHORT_C(SHORT_CYC), .LONG_C(LONG_CYC)
    ) dwell_i (
        .st     (r_d.st),
        .long_w (r_d.long_w),
        .val    (t_val)
    );

    lcdw_timer #(.W(CW)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            W_IDLE: begin
                if (host_valid) begin
                    r_d.st     = W_SETUP_H;
                    r_d.lo     = host_byte[3:0];
                    r_d.long_w = cls_long;
                    r_d.rs     = host_is_data;
                    r_d.d      = host_byte[7:4];
                end
            end
            W_SETUP_H: if (t_exp) begin r_d.st = W_PULSE_H; r_d.en = 1'b1; end
            W_PULSE_H: if (t_exp) begin r_d.st = W_HOLD_H;  r_d.en = 1'b0; end
            W_HOLD_H:  if (t_exp) begin r_d.st = W_SETUP_L; r_d.d  = r_q.lo; end
            W_SETUP_L: if (t_exp) begin r_d.st = W_PULSE_L; r_d.en = 1'b1; end
            W_PULSE_L: if (t_exp) begin r_d.st = W_HOLD_L;  r_d.en = 1'b0; end
            W_HOLD_L: begin
                if (t_exp) begin
                    r_d.st = W_SETTLE;
                    r_d.d  = 4'h0;
                    r_d.rs = 1'b0;
                end
            end
            W_SETTLE:  if (t_exp) r_d.st = W_IDLE;
            default:   r_d.st = W_IDLE;
        endcase
        t_load = (r_d.st != r_q.st) && (r_d.st != W_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st     <= W_IDLE;
            r_q.lo     <= 4'h0;
            r_q.long_w <= 1'b0;
            r_q.en     <= 1'b0;
            r_q.rs     <= 1'b0;
            r_q.d      <= 4'h0;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_ready = (r_q.st == W_IDLE);
    assign lcd_d      = r_q.d;
    assign lcd_rs     = r_q.rs;
    assign lcd_en     = r_q.en;
    assign lcd_rw     = 1'b0;
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker
    import lcdw_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 200,
    parameter int unsigned EN_NS   = 450
) (
    input logic       clk,
    input logic       rst,
    input logic       host_valid,
    input logic       host_ready,
    input logic [3:0] lcd_d,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_en
);
    localparam int unsigned EN_CYC = ns2cyc(EN_NS, CLK_MHZ);

    logic [31:0] en_cnt_q;
    always_ff @(posedge clk) begin
        if (rst)         en_cnt_q <= '0;
        else if (lcd_en) en_cnt_q <= en_cnt_q + 32'd1;
        else             en_cnt_q <= '0;
    end

    // R3
    rw_low_chk: assert property (@(posedge clk) disable iff (rst) !lcd_rw);

    // R4
    en_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_en) |-> (en_cnt_q >= EN_CYC));

    // R5
    strobe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_en |=> $stable({lcd_d, lcd_rs}));

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> !host_ready);

    // R9
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_ready) |=> !host_ready);

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!lcd_en && host_ready && (lcd_d == 4'h0)));
endmodule

bind lcd_nibble_writer lcdw_checker #(.CLK_MHZ(CLK_MHZ), .EN_NS(EN_NS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .lcd_d      (lcd_d),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_en     (lcd_en)
);

// File: tb/lcd_nibble_writer_tb_top.sv
`timescale 1ns/1ps
module lcd_nibble_writer_tb_top;
    localparam int MHZ = 200, EN_NS = 450, HOLD_NS = 12, GAP_NS = 1000;
    localparam int SHORT_NS = 2000, LONG_NS = 9000;
    // Expected cycle counts, rounded up from the nanosecond values.
    localparam int E_EN    = (EN_NS * MHZ + 999) / 1000;     // 90
    localparam int E_HOLD  = (HOLD_NS * MHZ + 999) / 1000;   // 3
    localparam int E_GAP   = (GAP_NS * MHZ + 999) / 1000;    // 200
    localparam int E_SHORT = (SHORT_NS * MHZ + 999) / 1000;  // 400
    localparam int E_LONG  = (LONG_NS * MHZ + 999) / 1000;   // 1800

    logic clk = 1'b0, rst = 1'b1;
    logic host_valid = 1'b0, host_is_data = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic host_ready, lcd_rs, lcd_rw, lcd_en;
    logic [3:0] lcd_d;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    lcd_nibble_writer #(
        .CLK_MHZ(MHZ), .EN_NS(EN_NS), .HOLD_NS(HOLD_NS), .GAP_NS(GAP_NS),
        .SHORT_NS(SHORT_NS), .LONG_NS(LONG_NS)
    ) dut_i (.*);

    // Monitor sampled on the falling clock edge.
    int cyc = 0, nstr = 0, rw_hi = 0;
    int rise_c[64], fall_c[64], setup_c[64], hold_c[64];
    logic [3:0] nib_c[64];
    logic rs_c[64];
    int last_chg = 0, ready_rise = 0, ready_fall = 0;
    logic p_en = 1'b0, p_rdy = 1'b0, hold_pend = 1'b0;
    logic [4:0] p_bus = 5'h0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (lcd_rw) rw_hi = rw_hi + 1;
        if ({lcd_d, lcd_rs} != p_bus) begin
            last_chg = cyc;
            if (hold_pend && nstr > 0) begin
                hold_c[(nstr - 1) & 63] = cyc - fall_c[(nstr - 1) & 63];
                hold_pend = 1'b0;
            end
        end
        if (lcd_en && !p_en) begin
            rise_c[nstr & 63]  = cyc;
            setup_c[nstr & 63] = cyc - last_chg;
        end
        if (lcd_en) begin
            nib_c[nstr & 63] = lcd_d;
            rs_c[nstr & 63]  = lcd_rs;
        end
        if (!lcd_en && p_en) begin
            fall_c[nstr & 63] = cyc;
            hold_c[nstr & 63] = 9999;
            hold_pend = 1'b1;
            nstr = nstr + 1;
        end
        if (host_ready && !p_rdy) ready_rise = cyc;
        if (!host_ready && p_rdy) ready_fall = cyc;
        p_en = lcd_en; p_rdy = host_ready; p_bus = {lcd_d, lcd_rs};
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        @(negedge clk); #1;
        while (!host_ready) begin @(negedge clk); #1; end
    endtask

    // Check one finished byte whose strobes start at index b.
    task automatic judge(input int b, input logic [7:0] byt, input logic isd, input int wait_c);
        chk(nstr == b + 2, "R1 strobe count", nstr - b, 2);
        chk(nib_c[b & 63] == byt[7:4], "R1 high nibble", int'(nib_c[b & 63]), int'(byt[7:4]));
        chk(nib_c[(b + 1) & 63] == byt[3:0], "R1 low nibble", int'(nib_c[(b + 1) & 63]), int'(byt[3:0]));
        chk(rs_c[b & 63] == isd && rs_c[(b + 1) & 63] == isd, "R2 rs level",
            int'(rs_c[(b + 1) & 63]), int'(isd));
        chk(fall_c[b & 63] - rise_c[b & 63] == E_EN, "R4 enable width",
            fall_c[b & 63] - rise_c[b & 63], E_EN);
        chk(setup_c[b & 63] >= E_EN && setup_c[(b + 1) & 63] >= E_EN, "R5 setup",
            setup_c[(b + 1) & 63], E_EN);
        chk(hold_c[b & 63] >= E_HOLD && hold_c[(b + 1) & 63] >= E_HOLD, "R5 hold",
            hold_c[(b + 1) & 63], E_HOLD);
        chk(rise_c[(b + 1) & 63] - fall_c[b & 63] >= E_GAP, "R6 nibble gap",
            rise_c[(b + 1) & 63] - fall_c[b & 63], E_GAP);
        chk(ready_rise - fall_c[(b + 1) & 63] == E_HOLD + wait_c,
            (wait_c == E_LONG) ? "R7 long settle" : "R8 short settle",
            ready_rise - fall_c[(b + 1) & 63], E_HOLD + wait_c);
    endtask

    task automatic send(input logic [7:0] byt, input logic isd, input int wait_c);
        int b;
        wait_ready();
        b = nstr;
        host_valid = 1'b1; host_byte = byt; host_is_data = isd;
        @(negedge clk);
        host_valid = 1'b0; host_byte = ~byt; host_is_data = ~isd;
        #1;
        chk(!host_ready, "R9 ready drops after handshake", int'(host_ready), 0);
        wait_ready();
        judge(b, byt, isd, wait_c);
    endtask

    task automatic t_reset_state();
        #1;
        chk(!lcd_en && lcd_d == 4'h0 && host_ready, "R10 state in reset",
            {lcd_en, lcd_d, host_ready}, 1);
        chk(!lcd_rw, "R3 rw low", int'(lcd_rw), 0);
    endtask

    task automatic t_data_bytes();
        send(8'h48, 1'b1, E_SHORT);  // R2 data register
        send(8'hA5, 1'b1, E_SHORT);
        send(8'h01, 1'b1, E_SHORT);  // R8 data 0x01 is not a clear
    endtask

    task automatic t_commands();
        send(8'h01, 1'b0, E_LONG);   // R7 clear
        send(8'h02, 1'b0, E_LONG);   // R7 home
        send(8'h03, 1'b0, E_LONG);   // R7 home, low bit ignored
        send(8'h04, 1'b0, E_SHORT);  // R8
        send(8'h00, 1'b0, E_SHORT);  // R8
        send(8'h81, 1'b0, E_SHORT);  // R8
    endtask

    task automatic t_busy_back_to_back();
        int b, rdy_cnt;
        wait_ready();
        b = nstr;
        host_valid = 1'b1; host_byte = 8'h3C; host_is_data = 1'b1;
        @(negedge clk);
        host_byte = 8'h02; host_is_data = 1'b0;  // held through the whole first byte
        rdy_cnt = 0;
        while (nstr < b + 2 || !host_ready) begin
            @(negedge clk); #1;
            if (host_ready) rdy_cnt++;
        end
        @(negedge clk); #1;
        if (host_ready) rdy_cnt++;
        host_valid = 1'b0;
        chk(rdy_cnt == 1, "R9 ready one cycle on back-to-back", rdy_cnt, 1);
        chk(nib_c[b & 63] == 4'h3 && nib_c[(b + 1) & 63] == 4'hC, "R9 busy inputs ignored",
            int'({nib_c[b & 63], nib_c[(b + 1) & 63]}), 8'h3C);
        chk(ready_rise - fall_c[(b + 1) & 63] == E_HOLD + E_SHORT, "R8 settle before next",
            ready_rise - fall_c[(b + 1) & 63], E_HOLD + E_SHORT);
        wait_ready();
        judge(b + 2, 8'h02, 1'b0, E_LONG);
    endtask

    task automatic t_reset_abort();
        wait_ready();
        host_valid = 1'b1; host_byte = 8'hF0; host_is_data = 1'b1;
        @(negedge clk); host_valid = 1'b0;
        repeat (120) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!lcd_en && lcd_d == 4'h0 && host_ready, "R10 abort clears outputs",
            {lcd_en, lcd_d, host_ready}, 1);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(!lcd_en && host_ready, "R10 idle after reset", {lcd_en, host_ready}, 1);
        send(8'h5A, 1'b1, E_SHORT);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                t_reset_state();
                rst = 1'b0;
                t_data_bytes();
                t_commands();
                t_busy_back_to_back();
                t_reset_abort();
                chk(rw_hi == 0, "R3 rw never high", rw_hi, 0);
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog", cyc, 0);
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule